// File: doc/BRIEF.md
# UART receive FIFO trigger controller

This block holds the receive and transmit byte queues of one UART channel, together with the write-only control register that manages them. A receive deserializer pushes finished characters in. The host drains them through receive-buffer reads. The host fills the transmit queue through holding-register writes, and the transmitter shifter pops bytes out. Three flags go to the interrupt logic: data ready, received data available (queue at or above a programmable trigger level), and a character timeout.

The receive trigger level comes from one of two tables, chosen by the `alt_mode` input. Control writes are gated by the enable bit. Whenever the enable bit changes value, both queues are emptied. While disabled, each queue holds a single character.

Flow rules:
- The receive push port has no back-pressure. A character that arrives when the queue is full is discarded, and `overrun` pulses.
- The host write port follows valid/ready. A byte transfers on a clock edge where `thr_valid` and `thr_ready` are both high, and `thr_ready` is low while the transmit queue is full.
- The transmitter pop port follows valid/ready. `tx_pop_valid` means a byte is waiting, and a byte leaves on an edge where valid and ready are both high.
- `rbr_data` always shows the oldest received byte. A pulse on `rbr_rd` removes that byte, and the pulse is ignored when the queue is empty.

Top module: `uart_fifo_trig`

## Requirements
- R1: Control bit 0 is the queue enable, and reset leaves it at 0. Bits 7:6, 2 and 1 of a control write take effect only when bit 0 of that same write is 1. While the block is disabled, a write of 0x02 leaves a stored receive byte in place.
- R2: A control write whose bit 0 differs from the current enable empties both queues, so both levels read 0 on the next cycle.
- R3: A control write with bits 0 and 1 set empties the receive queue. The bit does not stay set, so a later write of 0x01 leaves the receive level unchanged.
- R4: A control write with bits 0 and 2 set empties the transmit queue and leaves the receive queue unchanged.
- R5: With `alt_mode` low, control bits 7:6 equal to 00, 01, 10 and 11 select trigger levels of 1, 4, 8 and 14 bytes.
- R6: With `alt_mode` high, the same codes select trigger levels of 1, 8, 16 and 28 bytes.
- R7: `rx_avail` is high while the block is enabled and the receive level is at or above the trigger level. It drops in the cycle after a read takes the level below the trigger level.
- R8: `data_ready` is high exactly when the receive queue holds at least one byte. It rises the cycle after a push into an empty queue and falls the cycle after the last byte is read.
- R9: While enabled, `rx_timeout` rises on the fourth `char_tick` after the last push or pop, provided the receive queue holds a byte.
- R10: A receive-buffer read clears `rx_timeout`. Every push or pop restarts the tick count.
- R11: Each queue holds 32 bytes when enabled. A push into a full receive queue is dropped, leaves the stored bytes and the level unchanged, and raises `overrun` for exactly one cycle.
- R12: The transmit queue delivers bytes in write order. `thr_ready` is low while it holds 32 bytes, and a write attempted then is not taken.
- R13: While disabled, each queue holds one byte. A second receive push is dropped with `overrun`, and `rx_avail` and `rx_timeout` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_mode | input | 1 | Selects the alternate trigger table |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| rx_push_valid | input | 1 | Deserializer has a character |
| rx_push_data | input | 8 | Deserialized character |
| thr_valid | input | 1 | Host offers a transmit byte |
| thr_ready | output | 1 | Transmit queue has room |
| thr_data | input | 8 | Host transmit byte |
| tx_pop_valid | output | 1 | Transmit byte waiting |
| tx_pop_ready | input | 1 | Shifter takes the byte |
| tx_pop_data | output | 8 | Oldest transmit byte |
| rbr_rd | input | 1 | Host receive-buffer read strobe |
| rbr_data | output | 8 | Oldest received byte |
| char_tick | input | 1 | One pulse per character time |
| rx_level | output | 6 | Receive queue occupancy |
| tx_level | output | 6 | Transmit queue occupancy |
| data_ready | output | 1 | Receive queue not empty |
| rx_avail | output | 1 | Receive level at or above trigger |
| rx_timeout | output | 1 | Character timeout flag |
| overrun | output | 1 | One-cycle pulse when a receive push is dropped |

## Verification
The hardest conditions to reach are the top trigger levels and the full-queue overrun. Each one needs 28 to 33 pushes with no reads in between. The vector loop therefore clears the queue and pushes up to the trigger level for every entry of both tables. It checks the level one byte below, at the level, and after one read.

The timeout restart needs a push to land part-way through a tick count. The bench places a second push after two ticks and then counts four more ticks. The enable gating is observed in disabled mode, where the one-byte capacity makes a surviving byte visible on `rx_level`.

// File: rtl/rxtrig_pkg.sv
package rxtrig_pkg;

  typedef struct packed {
    logic       en;
    logic [1:0] trig;
  } fifo_ctl_t;

  function automatic int unsigned trig_bytes(input logic alt, input logic [1:0] code);
    int unsigned lvl;
    case (code)
      2'd0:    lvl = 1;
      2'd1:    lvl = alt ? 8  : 4;
      2'd2:    lvl = alt ? 16 : 8;
      default: lvl = alt ? 28 : 14;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap_one,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  output logic          push_ready,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign push_ready = cap_one ? (level == '0) : (level != CW'(DEPTH));
  assign pop_valid  = (level != '0);
  assign pop_data   = mem[rd_ptr];
  assign do_push    = push_valid && push_ready && !clr;
  assign do_pop     = pop_ready && pop_valid && !clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R11
  full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready && !pop_ready && !clr) |=> $stable(level));

  // R3
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == '0));

endmodule

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg
  import rxtrig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output fifo_ctl_t  ctl,
  output logic       clr_rx,
  output logic       clr_tx
);

  logic en_flip;

  assign en_flip = wr_en && (wr_data[0] != ctl.en);
  assign clr_rx  = en_flip || (wr_en && wr_data[0] && wr_data[1]);
  assign clr_tx  = en_flip || (wr_en && wr_data[0] && wr_data[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl.en <= wr_data[0];
      if (wr_data[0]) ctl.trig <= wr_data[7:6];
    end
  end

  // R1
  gated_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |=> $stable(ctl.trig));

endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic nonempty,
  input  logic restart,
  input  logic drop,
  input  logic tick,
  output logic flag
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (restart || !nonempty || !enable) cnt <= '0;
      else if (tick && cnt != TW'(LIMIT)) cnt <= cnt + 1'b1;

      if (drop || !enable) flag <= 1'b0;
      else if (!restart && nonempty && tick && cnt == TW'(LIMIT - 1)) flag <= 1'b1;
    end
  end

  // R9
  timeout_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));

  // R10
  read_clears_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !flag);

endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig
  import rxtrig_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned TO_TICKS = 4,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_mode,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              rx_push_valid,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic              thr_valid,
  output logic              thr_ready,
  input  logic [DATA_W-1:0] thr_data,
  output logic              tx_pop_valid,
  input  logic              tx_pop_ready,
  output logic [DATA_W-1:0] tx_pop_data,
  input  logic              rbr_rd,
  output logic [DATA_W-1:0] rbr_data,
  input  logic              char_tick,
  output logic [CW-1:0]     rx_level,
  output logic [CW-1:0]     tx_level,
  output logic              data_ready,
  output logic              rx_avail,
  output logic              rx_timeout,
  output logic              overrun
);

  fifo_ctl_t      ctl;
  logic           clr_rx, clr_tx;
  logic           rx_room, rx_nonempty;
  logic           rx_take, rx_put;
  logic [CW-1:0]  trig_lvl;

  fifo_ctl_reg u_ctl (
    .clk, .rst_n,
    .wr_en   (ctl_we),
    .wr_data (ctl_wdata),
    .ctl     (ctl),
    .clr_rx  (clr_rx),
    .clr_tx  (clr_tx)
  );

  byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n,
    .clr        (clr_rx),
    .cap_one    (!ctl.en),
    .push_valid (rx_push_valid),
    .push_data  (rx_push_data),
    .push_ready (rx_room),
    .pop_valid  (rx_nonempty),
    .pop_ready  (rbr_rd),
    .pop_data   (rbr_data),
    .level      (rx_level)
  );

  byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n,
    .clr        (clr_tx),
    .cap_one    (!ctl.en),
    .push_valid (thr_valid),
    .push_data  (thr_data),
    .push_ready (thr_ready),
    .pop_valid  (tx_pop_valid),
    .pop_ready  (tx_pop_ready),
    .pop_data   (tx_pop_data),
    .level      (tx_level)
  );

  assign rx_take    = rbr_rd && rx_nonempty;
  assign rx_put     = rx_push_valid && rx_room;
  assign trig_lvl   = CW'(trig_bytes(alt_mode, ctl.trig));
  assign data_ready = rx_nonempty;
  assign rx_avail   = ctl.en && (rx_level >= trig_lvl);

  rx_char_timer #(.LIMIT(TO_TICKS)) u_tmr (
    .clk, .rst_n,
    .enable   (ctl.en),
    .nonempty (rx_nonempty),
    .restart  (rx_take || rx_put || clr_rx),
    .drop     (rx_take || clr_rx),
    .tick     (char_tick),
    .flag     (rx_timeout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) overrun <= 1'b0;
    else        overrun <= rx_push_valid && !rx_room && !clr_rx;
  end

  // R2
  enable_flip_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (ctl_wdata[0] != ctl.en)) |=> (rx_level == '0 && tx_level == '0));

  // R8
  push_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_valid && !rx_nonempty && !clr_rx) |=> data_ready);

  // R11
  overrun_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(!rx_room));

  // R13
  disabled_no_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |-> (!rx_avail && rx_level <= CW'(1)));

endmodule

// File: tb/test_uart_fifo_trig.sv
module test_uart_fifo_trig;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alt_mode = 1'b0, ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       rx_push_valid = 1'b0;
  logic [7:0] rx_push_data = '0;
  logic       thr_valid = 1'b0, thr_ready;
  logic [7:0] thr_data = '0;
  logic       tx_pop_valid, tx_pop_ready = 1'b0;
  logic [7:0] tx_pop_data, rbr_data;
  logic       rbr_rd = 1'b0, char_tick = 1'b0;
  logic [5:0] rx_level, tx_level;
  logic       data_ready, rx_avail, rx_timeout, overrun;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_fifo_trig i_uart_fifo_trig (.*);

  // {alt, code[1:0], level[4:0]}
  localparam logic [7:0] VEC [8] = '{
    {1'b0, 2'd0, 5'd1},  {1'b0, 2'd1, 5'd4},  {1'b0, 2'd2, 5'd8},  {1'b0, 2'd3, 5'd14},
    {1'b1, 2'd0, 5'd1},  {1'b1, 2'd1, 5'd8},  {1'b1, 2'd2, 5'd16}, {1'b1, 2'd3, 5'd28}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_push_valid = 1'b1; rx_push_data = b;
    @(negedge clk);
    rx_push_valid = 1'b0;
  endtask

  task automatic rd();
    rbr_rd = 1'b1;
    @(negedge clk);
    rbr_rd = 1'b0;
  endtask

  task automatic cw(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic thr(input logic [7:0] b);
    thr_valid = 1'b1; thr_data = b;
    @(negedge clk);
    thr_valid = 1'b0;
  endtask

  task automatic tpop();
    tx_pop_ready = 1'b1;
    @(negedge clk);
    tx_pop_ready = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1;
    @(negedge clk);
    char_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R8)
    chk(rx_level == 0 && tx_level == 0, "R1 reset levels", rx_level, 0);
    chk(!data_ready && !rx_avail && !rx_timeout && !overrun, "R8 reset flags", data_ready, 0);
    chk(thr_ready && !tx_pop_valid, "R12 reset tx handshake", thr_ready, 1);

    // disabled mode: one byte deep (R13)
    push(8'h11);
    chk(rx_level == 1 && data_ready, "R13 first push while disabled", rx_level, 1);
    push(8'h22);
    chk(overrun == 1'b1, "R13 overrun on second push", overrun, 1);
    chk(rx_level == 1 && !rx_avail, "R13 level held at one", rx_level, 1);
    chk(rbr_data == 8'h11, "R13 first byte kept", rbr_data, 8'h11);
    // R1: bit1 ignored without bit0
    cw(8'h02);
    chk(rx_level == 1, "R1 clear ignored while disabled", rx_level, 1);
    // R2: enabling empties
    thr(8'h99);
    cw(8'h01);
    chk(rx_level == 0 && tx_level == 0, "R2 enable flip empties", rx_level, 0);

    // trigger vector walk (R5, R6, R7)
    foreach (VEC[i]) begin
      int lvl;
      alt_mode = VEC[i][7];
      lvl = int'(VEC[i][4:0]);
      cw({VEC[i][6:5], 3'b000, 3'b011});
      chk(rx_level == 0, "R3 clear before vector", rx_level, 0);
      for (int k = 0; k < lvl - 1; k++) push(8'(k));
      chk(!rx_avail, VEC[i][7] ? "R6 below trigger" : "R5 below trigger", rx_avail, 0);
      push(8'hEE);
      chk(rx_avail, VEC[i][7] ? "R6 at trigger" : "R5 at trigger", rx_avail, 1);
      rd();
      chk(!rx_avail, "R7 drops after read", rx_avail, 0);
    end
    alt_mode = 1'b0;

    // R2: disabling empties too
    push(8'h01);
    cw(8'h00);
    chk(rx_level == 0, "R2 disable flip empties", rx_level, 0);
    cw(8'h01);

    // R4 and R3 selective clears
    push(8'hA1); push(8'hA2); push(8'hA3);
    thr(8'hB1); thr(8'hB2);
    cw(8'h05);
    chk(tx_level == 0, "R4 tx cleared", tx_level, 0);
    chk(rx_level == 3, "R4 rx untouched", rx_level, 3);
    cw(8'h03);
    chk(rx_level == 0 && !data_ready, "R3 rx cleared", rx_level, 0);
    push(8'hC1);
    cw(8'h01);
    chk(rx_level == 1, "R3 bit does not stick", rx_level, 1);
    rd();
    chk(!data_ready, "R8 empty after last read", data_ready, 0);

    // R12 transmit order and full
    for (int k = 0; k < 32; k++) thr(8'h40 + 8'(k));
    chk(!thr_ready && tx_level == 32, "R12 tx full", tx_level, 32);
    thr(8'hFF);
    chk(tx_level == 32, "R12 write refused when full", tx_level, 32);
    chk(tx_pop_valid && tx_pop_data == 8'h40, "R12 first out", tx_pop_data, 8'h40);
    tpop();
    chk(tx_pop_data == 8'h41, "R12 second out", tx_pop_data, 8'h41);
    tpop();
    chk(tx_level == 30 && thr_ready, "R12 room after pops", tx_level, 30);

    // R11 overrun when full
    for (int k = 0; k < 32; k++) push(8'h80 + 8'(k));
    chk(!overrun && rx_level == 32, "R11 full without overrun", rx_level, 32);
    push(8'h5A);
    chk(overrun && rx_level == 32, "R11 overrun pulse", overrun, 1);
    @(negedge clk);
    chk(!overrun, "R11 overrun one cycle", overrun, 0);
    chk(rbr_data == 8'h80, "R11 oldest byte kept", rbr_data, 8'h80);
    cw(8'h03);

    // R9 timeout
    push(8'h33);
    tick(); tick(); tick();
    chk(!rx_timeout, "R9 low after three ticks", rx_timeout, 0);
    tick();
    chk(rx_timeout, "R9 high after four ticks", rx_timeout, 1);
    rd();
    chk(!rx_timeout, "R10 read clears timeout", rx_timeout, 0);
    // R10 restart on push
    push(8'h34);
    tick(); tick();
    push(8'h35);
    tick(); tick(); tick();
    chk(!rx_timeout, "R10 restart after push", rx_timeout, 0);
    tick();
    chk(rx_timeout, "R10 fires after restart", rx_timeout, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule